// File: doc/BRIEF.md
# Indexed Real-Time Clock

This block is a small calendar clock that software reaches through two byte-wide ports. A write to the index port selects one of the clock's registers; a read strobe on the data port then returns that register's contents one cycle later. The clock keeps binary seconds, minutes, hours, day of week, day of month, month and year. A reset loads the running time from a parallel set of initial-value inputs.

All timekeeping comes from a single tick-enable input. A prescaler turns these ticks into a periodic interrupt pulse at a nominal 1024 Hz. A second counter turns the same ticks into a once-per-second update that ripples through the calendar fields, including month lengths and leap years. The control registers are constants, except for one live bit in register A. That bit warns software that a seconds update is about to land. Any write on the data port is refused and flagged.

Top module: `rtc_indexed`

## Requirements
- R1: A write on `idx_we` stores `idx_wdata` as the current index. A `dat_re` pulse returns the indexed register on `rd_data` with `rd_valid` high in the next cycle. The index stays in force across any number of reads. The time indices are 0x00 seconds, 0x02 minutes, 0x04 hours, 0x06 day of week, 0x07 day of month, 0x08 month and 0x09 year.
- R2: Index 0x0A reads as the update-in-progress flag in bit 7, with 0x26 in bits 6:0.
- R3: Index 0x0B reads as 0x46 (binary data, 24-hour format, periodic interrupt enabled), and index 0x0C reads as 0x00.
- R4: Index 0x0D, and any index not listed in R1 to R3, reads with `rd_err` high alongside `rd_valid`, and `rd_data` is 0x00.
- R5: Reset loads every time field from the `init_*` inputs. The month is 1-based (1 to 12), and the year field holds the calendar year minus 1952.
- R6: Seconds advance once every TICKS_PER_IRQ*IRQ_PER_SEC asserted `tick_en` cycles. A seconds carry at 59 ripples through minutes (at 59), hours (at 23), day of week (0 to 6, 6 wraps to 0) and day of month.
- R7: The day of month wraps to 1 after the month's last day. April, June, September and November have 30 days, and February has 29 in a Gregorian leap year and 28 otherwise. The month wraps from 12 to 1 and then increments the year, and year 255 wraps to 0.
- R8: `irq` is a single-cycle pulse, issued once every TICKS_PER_IRQ asserted `tick_en` cycles whatever the register traffic.
- R9: The update-in-progress flag is high during the last UIP_WIN `tick_en` counts before each seconds update. It drops in the same cycle that the seconds field changes.
- R10: A `dat_we` pulse raises `wr_err` for one cycle in the next cycle and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads the initial time |
| tick_en | input | 1 | Time-base tick enable |
| init_sec | input | 6 | Initial seconds (0-59) |
| init_min | input | 6 | Initial minutes (0-59) |
| init_hour | input | 5 | Initial hours (0-23) |
| init_wday | input | 3 | Initial day of week (0-6) |
| init_mday | input | 5 | Initial day of month (1-31) |
| init_mon | input | 4 | Initial month (1-12) |
| init_year | input | 8 | Initial year minus 1952 |
| idx_we | input | 1 | Index port write strobe |
| idx_wdata | input | 8 | Index value |
| dat_re | input | 1 | Data port read strobe |
| dat_we | input | 1 | Data port write strobe (refused) |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid, one cycle after `dat_re` |
| rd_err | output | 1 | Read of an unsupported index |
| wr_err | output | 1 | Refused data-port write |
| irq | output | 1 | Periodic interrupt pulse |

## Verification
The bench builds the clock with TICKS_PER_IRQ = 2, IRQ_PER_SEC = 4 and UIP_WIN = 3, so one second takes only eight tick enables. With that setting a single test can watch the update-in-progress bit rise and fall, and can count interrupt pulses against ticks. Each calendar boundary is reached by resetting to a time one second before it: a leap and a non-leap February end, a 30-day month end, a year end, a century year that is not leap, a century year that is leap, and the year-field wrap.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [3:0] mon;
        logic [4:0] mday;
        logic [2:0] wday;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } rtc_time_t;

    // Register indices decoded by software
    localparam logic [7:0] IDX_SEC   = 8'h00;
    localparam logic [7:0] IDX_MIN   = 8'h02;
    localparam logic [7:0] IDX_HOUR  = 8'h04;
    localparam logic [7:0] IDX_WDAY  = 8'h06;
    localparam logic [7:0] IDX_MDAY  = 8'h07;
    localparam logic [7:0] IDX_MON   = 8'h08;
    localparam logic [7:0] IDX_YEAR  = 8'h09;
    localparam logic [7:0] IDX_CTLA  = 8'h0A;
    localparam logic [7:0] IDX_CTLB  = 8'h0B;
    localparam logic [7:0] IDX_CTLC  = 8'h0C;

    localparam logic [6:0] CTLA_LOW  = 7'h26;
    localparam logic [7:0] CTLB_VAL  = 8'h46;
    localparam logic [11:0] YEAR_BASE = 12'd1952;

    function automatic logic is_leap(input logic [7:0] yoff);
        logic [11:0] yr;
        yr = YEAR_BASE + {4'd0, yoff};
        return ((yr % 12'd4) == 12'd0) &&
               (((yr % 12'd100) != 12'd0) || ((yr % 12'd400) == 12'd0));
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] mon, input logic leap);
        case (mon)
            4'd2:                      return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int TICKS_PER_IRQ = 32,
    parameter int IRQ_PER_SEC   = 1024,
    parameter int UIP_WIN       = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    output logic sec_tick,
    output logic irq,
    output logic uip
);
    localparam int TPS   = TICKS_PER_IRQ * IRQ_PER_SEC;
    localparam int PRE_W = (TICKS_PER_IRQ > 1) ? $clog2(TICKS_PER_IRQ) : 1;
    localparam int TOT_W = (TPS > 1) ? $clog2(TPS) : 1;
    localparam logic [PRE_W-1:0] LAST_PRE  = PRE_W'(TICKS_PER_IRQ - 1);
    localparam logic [TOT_W-1:0] LAST_TOT  = TOT_W'(TPS - 1);
    localparam logic [TOT_W-1:0] UIP_START = TOT_W'(TPS - UIP_WIN);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [TOT_W-1:0] tot;
        logic             irq;
        logic             uip;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (tick_en) begin
            if (st_q.pre == LAST_PRE) begin
                st_d.pre = '0;
                st_d.irq = 1'b1;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
            if (st_q.tot == LAST_TOT) begin
                st_d.tot = '0;
            end else begin
                st_d.tot = st_q.tot + 1'b1;
            end
        end
        st_d.uip = (st_d.tot >= UIP_START);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_tick = tick_en && (st_q.tot == LAST_TOT);
    assign irq      = st_q.irq;
    assign uip      = st_q.uip;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sec_tick,
    input  rtc_time_t init_time,
    output rtc_time_t now
);
    rtc_time_t cal_d, cal_q;

    always_comb begin
        cal_d = cal_q;
        if (sec_tick) begin
            if (cal_q.sec != 6'd59) begin
                cal_d.sec = cal_q.sec + 6'd1;
            end else begin
                cal_d.sec = 6'd0;
                if (cal_q.min != 6'd59) begin
                    cal_d.min = cal_q.min + 6'd1;
                end else begin
                    cal_d.min = 6'd0;
                    if (cal_q.hour != 5'd23) begin
                        cal_d.hour = cal_q.hour + 5'd1;
                    end else begin
                        cal_d.hour = 5'd0;
                        cal_d.wday = (cal_q.wday == 3'd6) ? 3'd0 : cal_q.wday + 3'd1;
                        if (cal_q.mday != month_len(cal_q.mon, is_leap(cal_q.year))) begin
                            cal_d.mday = cal_q.mday + 5'd1;
                        end else begin
                            cal_d.mday = 5'd1;
                            if (cal_q.mon != 4'd12) begin
                                cal_d.mon = cal_q.mon + 4'd1;
                            end else begin
                                cal_d.mon  = 4'd1;
                                cal_d.year = cal_q.year + 8'd1;
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_q <= init_time;
        end else begin
            cal_q <= cal_d;
        end
    end

    assign now = cal_q;
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_we,
    input  logic [7:0] idx_wdata,
    input  logic       dat_re,
    input  logic       dat_we,
    input  rtc_time_t  now,
    input  logic       uip,
    output logic [7:0] idx,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic       rd_err,
    output logic       wr_err
);
    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] rdata;
        logic       rvalid;
        logic       rerr;
        logic       werr;
    } reg_st_t;

    reg_st_t rs_d, rs_q;
    logic [7:0] sel_data;
    logic       sel_err;

    always_comb begin
        sel_err = 1'b0;
        case (rs_q.idx)
            IDX_SEC:  sel_data = {2'd0, now.sec};
            IDX_MIN:  sel_data = {2'd0, now.min};
            IDX_HOUR: sel_data = {3'd0, now.hour};
            IDX_WDAY: sel_data = {5'd0, now.wday};
            IDX_MDAY: sel_data = {3'd0, now.mday};
            IDX_MON:  sel_data = {4'd0, now.mon};
            IDX_YEAR: sel_data = now.year;
            IDX_CTLA: sel_data = {uip, CTLA_LOW};
            IDX_CTLB: sel_data = CTLB_VAL;
            IDX_CTLC: sel_data = 8'h00;
            default: begin
                sel_data = 8'h00;
                sel_err  = 1'b1;
            end
        endcase
    end

    always_comb begin
        rs_d        = rs_q;
        rs_d.rvalid = dat_re;
        rs_d.rerr   = dat_re && sel_err;
        rs_d.werr   = dat_we;
        if (dat_re) begin
            rs_d.rdata = sel_data;
        end
        if (idx_we) begin
            rs_d.idx = idx_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign idx      = rs_q.idx;
    assign rd_data  = rs_q.rdata;
    assign rd_valid = rs_q.rvalid;
    assign rd_err   = rs_q.rerr;
    assign wr_err   = rs_q.werr;
endmodule

// File: rtl/rtc_indexed.sv
module rtc_indexed
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_IRQ = 32,
    parameter int IRQ_PER_SEC   = 1024,
    parameter int UIP_WIN       = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [5:0] init_sec,
    input  logic [5:0] init_min,
    input  logic [4:0] init_hour,
    input  logic [2:0] init_wday,
    input  logic [4:0] init_mday,
    input  logic [3:0] init_mon,
    input  logic [7:0] init_year,
    input  logic       idx_we,
    input  logic [7:0] idx_wdata,
    input  logic       dat_re,
    input  logic       dat_we,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic       rd_err,
    output logic       wr_err,
    output logic       irq
);
    rtc_time_t  init_w;
    rtc_time_t  now_w;
    logic       sec_tick_w;
    logic       uip_w;
    logic [7:0] idx_w;

    assign init_w = '{year: init_year, mon: init_mon, mday: init_mday,
                      wday: init_wday, hour: init_hour, min: init_min,
                      sec: init_sec};

    rtc_tick_gen #(
        .TICKS_PER_IRQ (TICKS_PER_IRQ),
        .IRQ_PER_SEC   (IRQ_PER_SEC),
        .UIP_WIN       (UIP_WIN)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .sec_tick (sec_tick_w),
        .irq      (irq),
        .uip      (uip_w)
    );

    rtc_calendar u_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick_w),
        .init_time (init_w),
        .now       (now_w)
    );

    rtc_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_we    (idx_we),
        .idx_wdata (idx_wdata),
        .dat_re    (dat_re),
        .dat_we    (dat_we),
        .now       (now_w),
        .uip       (uip_w),
        .idx       (idx_w),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rd_err    (rd_err),
        .wr_err    (wr_err)
    );
endmodule

// File: rtl/rtc_indexed_chk.sv
module rtc_indexed_chk
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_IRQ = 32,
    parameter int IRQ_PER_SEC   = 1024,
    parameter int UIP_WIN       = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       dat_re,
    input logic       dat_we,
    input logic [7:0] rd_data,
    input logic       rd_valid,
    input logic       rd_err,
    input logic       wr_err,
    input logic       irq,
    input logic       uip,
    input logic       sec_tick,
    input logic [7:0] idx,
    input rtc_time_t  now
);
    // R1
    read_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_re |=> rd_valid);

    // R1
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_re |=> !rd_valid);

    // R2
    ctla_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_re && idx == IDX_CTLA) |=> (rd_data[6:0] == CTLA_LOW));

    // R4
    err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_valid && rd_data == 8'h00));

    // R6
    sec_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(now.sec));

    // R6
    clock_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (now.sec < 6'd60) && (now.min < 6'd60) && (now.hour < 5'd24) && (now.wday < 3'd7));

    // R7
    date_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (now.mon >= 4'd1) && (now.mon <= 4'd12) && (now.mday >= 5'd1) &&
        (now.mday <= month_len(now.mon, is_leap(now.year))));

    // R10
    write_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_we |=> (wr_err && $stable(idx)));

    generate
        if (TICKS_PER_IRQ > 1) begin : g_irq
            // R8
            irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq |=> !irq);
        end
        if (UIP_WIN < TICKS_PER_IRQ * IRQ_PER_SEC) begin : g_uip
            // R9
            uip_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sec_tick |=> !uip);
        end
    endgenerate
endmodule

bind rtc_indexed rtc_indexed_chk #(
    .TICKS_PER_IRQ (TICKS_PER_IRQ),
    .IRQ_PER_SEC   (IRQ_PER_SEC),
    .UIP_WIN       (UIP_WIN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dat_re   (dat_re),
    .dat_we   (dat_we),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .rd_err   (rd_err),
    .wr_err   (wr_err),
    .irq      (irq),
    .uip      (uip_w),
    .sec_tick (sec_tick_w),
    .idx      (idx_w),
    .now      (now_w)
);

// File: tb/tb_rtc_indexed.sv
`timescale 1ns/1ps
module tb_rtc_indexed;
    localparam int TPI = 2;
    localparam int IPS = 4;
    localparam int UWN = 3;
    localparam int TPS = TPI * IPS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [5:0] init_sec = '0;
    logic [5:0] init_min = '0;
    logic [4:0] init_hour = '0;
    logic [2:0] init_wday = '0;
    logic [4:0] init_mday = 5'd1;
    logic [3:0] init_mon = 4'd1;
    logic [7:0] init_year = '0;
    logic       idx_we = 1'b0;
    logic [7:0] idx_wdata = '0;
    logic       dat_re = 1'b0;
    logic       dat_we = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       rd_err;
    logic       wr_err;
    logic       irq;

    always #2 clk = ~clk;

    rtc_indexed #(.TICKS_PER_IRQ(TPI), .IRQ_PER_SEC(IPS), .UIP_WIN(UWN)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .init_sec(init_sec), .init_min(init_min), .init_hour(init_hour),
        .init_wday(init_wday), .init_mday(init_mday), .init_mon(init_mon),
        .init_year(init_year), .idx_we(idx_we), .idx_wdata(idx_wdata),
        .dat_re(dat_re), .dat_we(dat_we), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_err(rd_err), .wr_err(wr_err), .irq(irq)
    );

    int checks = 0;
    int errors = 0;

    // scoreboard queues
    logic [7:0] q_data[$];
    logic       q_err[$];
    string      q_tag[$];

    // reference model
    int m_sec, m_min, m_hour, m_wday, m_mday, m_mon, m_year, m_tcnt;
    int irq_seen = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit leap(input int off);
        int y;
        y = 1952 + off;
        return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    endfunction

    function automatic int mlen(input int mon, input int off);
        if (mon == 2) return leap(off) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_second();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hour++;
                if (m_hour == 24) begin
                    m_hour = 0;
                    m_wday = (m_wday + 1) % 7;
                    m_mday++;
                    if (m_mday > mlen(m_mon, m_year)) begin
                        m_mday = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1;
                            m_year = (m_year + 1) % 256;
                        end
                    end
                end
            end
        end
    endtask

    // monitor: pops expected reads as results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (q_data.size() == 0) begin
                check(1'b0, "R1 unexpected read result", rd_data, 0);
            end else begin
                logic [7:0] ed;
                logic       ee;
                string      et;
                ed = q_data.pop_front();
                ee = q_err.pop_front();
                et = q_tag.pop_front();
                check(rd_data == ed && rd_err == ee, et, {rd_err, rd_data}, {ee, ed});
            end
        end
    end

    always @(posedge clk) begin
        if (rst_n && irq) irq_seen++;
    end

    task automatic do_reset(input int s, input int mi, input int h, input int wd,
                            input int md, input int mo, input int y);
        @(negedge clk);
        rst_n = 1'b0;
        init_sec = 6'(s); init_min = 6'(mi); init_hour = 5'(h);
        init_wday = 3'(wd); init_mday = 5'(md); init_mon = 4'(mo); init_year = 8'(y);
        m_sec = s; m_min = mi; m_hour = h; m_wday = wd; m_mday = md; m_mon = mo; m_year = y;
        m_tcnt = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        irq_seen = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            m_tcnt++;
            if (m_tcnt == TPS) begin
                m_tcnt = 0;
                model_second();
            end
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic read_again(input logic [7:0] exp, input logic eerr, input string tag);
        @(negedge clk);
        idx_we = 1'b0;
        q_data.push_back(exp); q_err.push_back(eerr); q_tag.push_back(tag);
        dat_re = 1'b1;
        @(negedge clk);
        dat_re = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_reg(input logic [7:0] ix, input logic [7:0] exp, input logic eerr,
                            input string tag);
        @(negedge clk);
        idx_we = 1'b1; idx_wdata = ix;
        read_again(exp, eerr, tag);
    endtask

    task automatic read_time(input string tag);
        read_reg(8'h00, 8'(m_sec),  1'b0, {tag, " R1 sec"});
        read_reg(8'h02, 8'(m_min),  1'b0, {tag, " R1 min"});
        read_reg(8'h04, 8'(m_hour), 1'b0, {tag, " R6 hour"});
        read_reg(8'h06, 8'(m_wday), 1'b0, {tag, " R6 wday"});
        read_reg(8'h07, 8'(m_mday), 1'b0, {tag, " R7 mday"});
        read_reg(8'h08, 8'(m_mon),  1'b0, {tag, " R7 month"});
        read_reg(8'h09, 8'(m_year), 1'b0, {tag, " R7 year"});
    endtask

    function automatic logic [7:0] ctla_exp();
        return {(m_tcnt >= TPS - UWN) ? 1'b1 : 1'b0, 7'h26};
    endfunction

    task automatic edge_case(input int mo, input int md, input int y, input int wd,
                             input string tag);
        do_reset(59, 59, 23, wd, md, mo, y);
        ticks(TPS);
        read_time(tag);
    endtask

    bit done = 1'b0;

    initial begin
        #(4 * 200000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // leap February, 23:59:58, year 2024
        do_reset(58, 59, 23, 6, 28, 2, 72);
        @(negedge clk);
        check(rd_valid == 1'b0 && rd_err == 1'b0 && wr_err == 1'b0 && irq == 1'b0,
              "R5 reset outputs idle", {rd_valid, rd_err, wr_err, irq}, 0);
        read_time("R5 init");
        read_reg(8'h0A, 8'h26, 1'b0, "R2 ctla idle");
        read_reg(8'h0B, 8'h46, 1'b0, "R3 ctlb");
        read_again(8'h46, 1'b0, "R1 index kept ctlb");
        read_reg(8'h0C, 8'h00, 1'b0, "R3 ctlc");
        read_reg(8'h0D, 8'h00, 1'b1, "R4 ctld");
        read_reg(8'h33, 8'h00, 1'b1, "R4 unknown");
        read_reg(8'h01, 8'h00, 1'b1, "R4 gap index");

        // update-in-progress window
        ticks(TPS - UWN - 1);
        read_reg(8'h0A, ctla_exp(), 1'b0, "R9 before window");
        ticks(1);
        read_reg(8'h0A, ctla_exp(), 1'b0, "R9 window open");
        ticks(UWN - 1);
        read_reg(8'h0A, ctla_exp(), 1'b0, "R9 window last");
        ticks(1);
        read_reg(8'h0A, ctla_exp(), 1'b0, "R9 dropped after update");
        read_reg(8'h00, 8'(m_sec), 1'b0, "R6 sec advanced");
        ticks(TPS);
        read_time("R7 leap feb");
        @(negedge clk);
        @(negedge clk);
        check(irq_seen == (2 * TPS) / TPI, "R8 irq count", irq_seen, (2 * TPS) / TPI);

        // refused write
        read_reg(8'h00, 8'(m_sec), 1'b0, "R10 before write");
        @(negedge clk);
        dat_we = 1'b1;
        @(negedge clk);
        dat_we = 1'b0;
        check(wr_err == 1'b1, "R10 wr_err pulse", wr_err, 1);
        @(negedge clk);
        check(wr_err == 1'b0, "R10 wr_err single", wr_err, 0);
        read_again(8'(m_sec), 1'b0, "R10 sec unchanged");

        edge_case(2, 28, 73, 3, "R7 nonleap feb");
        edge_case(12, 31, 72, 2, "R7 year end");
        edge_case(4, 30, 80, 5, "R7 thirty day");
        edge_case(2, 28, 148, 6, "R7 century nonleap");
        edge_case(2, 28, 48, 1, "R7 century leap");
        edge_case(12, 31, 255, 4, "R7 year wrap");
        edge_case(3, 14, 10, 2, "R6 plain day");

        repeat (4) @(negedge clk);
        check(q_data.size() == 0, "R1 all reads answered", q_data.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule